// File: doc/BRIEF.md
# Physical Frame Ownership Table

This block keeps one record per physical memory frame, noting whether the frame is in use and, for a frame in use, which process owns it and which page of that process it holds. Memory management logic uses it to reserve frames for a new process and to give back every frame a process held when it leaves.

An allocation request names a process and a page count. The request is all-or-nothing. If the table holds enough free frames, it hands them out one per cycle, lowest-numbered free frame first, tagging each with the page index in ascending order so the caller can fill the page table of the process. If not enough frames are free, the request is refused in a single cycle and nothing changes. A release request walks every record, one per cycle, and frees each frame that the named process owns.

The controller has three states. IDLE waits for work. GRANT hands out one frame per cycle. SCAN walks the records for a release. The transitions are: IDLE to GRANT on an accepted allocation that fits and asks for at least one page; GRANT to IDLE after the final page; IDLE to SCAN on an accepted release; SCAN to IDLE after the last record. A refused request and a zero-page request both stay in IDLE.

Top module: `frame_alloc_table`

## Requirements
- R1: After reset, every frame is free, `free_count` equals NUM_FRAMES, and `busy`, `grant_valid`, `alloc_fail`, `alloc_done` and `rel_done` are all low.
- R2: An allocation asking for more pages than `free_count` is refused. `alloc_fail` pulses high in the cycle after the request. No grant follows, `busy` stays low, and `free_count` is unchanged.
- R3: An allocation for N pages, with 1 <= N <= `free_count`, yields exactly N grant cycles. They begin two cycles after the request and run back to back. `grant_page` runs 0, 1, ..., N-1. `alloc_done` is high together with the final grant.
- R4: Each grant names the lowest-numbered frame that is free at that moment. Frames need not be contiguous.
- R5: Each grant lowers `free_count` by one, and each frame freed by a release raises it by one.
- R6: A release walks all NUM_FRAMES records, one per cycle. It frees exactly the frames owned by the named process. `rel_done` pulses in the cycle after the last record is visited.
- R7: While `busy` is high (during GRANT or SCAN), new allocation and release requests are ignored.
- R8: When an allocation and a release are requested in the same idle cycle, the release is taken and the allocation is dropped.
- R9: An allocation for zero pages pulses `alloc_done` in the next cycle, with no grant and no change to the table.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alloc_req | input | 1 | Allocation request strobe |
| alloc_pid | input | PID_W | Process making the allocation |
| alloc_npages | input | CNT_W | Number of pages wanted |
| rel_req | input | 1 | Release request strobe |
| rel_pid | input | PID_W | Process whose frames are freed |
| busy | output | 1 | Allocation or release in progress |
| alloc_fail | output | 1 | One-cycle refusal pulse |
| alloc_done | output | 1 | Allocation finished |
| grant_valid | output | 1 | A frame grant is presented |
| grant_frame | output | FRAME_W | Granted frame number |
| grant_page | output | FRAME_W | Page index the frame serves |
| rel_done | output | 1 | Release walk finished |
| free_count | output | CNT_W | Number of free frames |

## Verification
The bench builds the table with NUM_FRAMES=8 and PID_W=3. With eight frames, a handful of requests can drain the table to zero, which reaches the refusal path with both a partly full and a completely full table. The short eight-cycle release walk keeps the number of cycles spent in SCAN small and lets the bench count them exactly. A release that opens holes in the middle of the table makes the next allocation pick non-contiguous frames, which exercises the lowest-free-first selection.

// File: rtl/fat_pkg.sv
package fat_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_GRANT = 2'd1,
        ST_SCAN  = 2'd2
    } fat_state_e;
endpackage

// File: rtl/fat_lowest_free.sv
module fat_lowest_free #(
    parameter int NUM_FRAMES = 16,
    localparam int FRAME_W = (NUM_FRAMES > 1) ? $clog2(NUM_FRAMES) : 1
) (
    input  logic [NUM_FRAMES-1:0] free_vec,
    output logic                  any_free,
    output logic [FRAME_W-1:0]    low_idx
);
    logic [NUM_FRAMES:0]   seen;
    logic [NUM_FRAMES-1:0] pick;

    assign seen[0] = 1'b0;

    for (genvar i = 0; i < NUM_FRAMES; i++) begin : g_chain
        assign pick[i]   = free_vec[i] & ~seen[i];
        assign seen[i+1] = seen[i] | free_vec[i];
    end

    assign any_free = seen[NUM_FRAMES];

    always_comb begin
        low_idx = '0;
        for (int k = 0; k < NUM_FRAMES; k++) begin
            if (pick[k]) low_idx = low_idx | FRAME_W'(k);
        end
    end

    always_comb begin
        a_r4_single_pick: assert ($onehot0(pick));
    end
endmodule

// File: rtl/fat_entry_store.sv
module fat_entry_store #(
    parameter int NUM_FRAMES = 16,
    parameter int PID_W      = 4,
    localparam int FRAME_W = (NUM_FRAMES > 1) ? $clog2(NUM_FRAMES) : 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  set_en,
    input  logic [FRAME_W-1:0]    set_idx,
    input  logic [PID_W-1:0]      set_pid,
    input  logic [FRAME_W-1:0]    set_page,
    input  logic                  clr_en,
    input  logic [FRAME_W-1:0]    clr_idx,
    input  logic [FRAME_W-1:0]    rd_idx,
    output logic                  rd_used,
    output logic [PID_W-1:0]      rd_pid,
    output logic [NUM_FRAMES-1:0] free_vec
);
    logic [NUM_FRAMES-1:0] used_q;
    logic [PID_W-1:0]      pid_q  [NUM_FRAMES];
    logic [FRAME_W-1:0]    page_q [NUM_FRAMES];

    for (genvar i = 0; i < NUM_FRAMES; i++) begin : g_entry
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                used_q[i] <= 1'b0;
                pid_q[i]  <= '0;
                page_q[i] <= '0;
            end else if (set_en && set_idx == FRAME_W'(i)) begin
                used_q[i] <= 1'b1;
                pid_q[i]  <= set_pid;
                page_q[i] <= set_page;
            end else if (clr_en && clr_idx == FRAME_W'(i)) begin
                used_q[i] <= 1'b0;
            end
        end
    end

    assign free_vec = ~used_q;

    always_comb begin
        rd_used = 1'b0;
        rd_pid  = '0;
        for (int k = 0; k < NUM_FRAMES; k++) begin
            if (rd_idx == FRAME_W'(k)) begin
                rd_used = used_q[k];
                rd_pid  = pid_q[k];
            end
        end
    end

    a_r4_set_only_free: assert property (@(posedge clk) disable iff (!rst_n)
        set_en |-> free_vec[set_idx]);
    a_r6_clear_only_used: assert property (@(posedge clk) disable iff (!rst_n)
        clr_en |-> !free_vec[clr_idx]);
    a_r7_no_set_and_clear: assert property (@(posedge clk) disable iff (!rst_n)
        !(set_en && clr_en));
endmodule

// File: rtl/fat_ctrl.sv
module fat_ctrl
    import fat_pkg::*;
#(
    parameter int NUM_FRAMES = 16,
    parameter int PID_W      = 4,
    localparam int FRAME_W = (NUM_FRAMES > 1) ? $clog2(NUM_FRAMES) : 1,
    localparam int CNT_W   = $clog2(NUM_FRAMES + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               alloc_req,
    input  logic [PID_W-1:0]   alloc_pid,
    input  logic [CNT_W-1:0]   alloc_npages,
    input  logic               rel_req,
    input  logic [PID_W-1:0]   rel_pid,
    input  logic               any_free,
    input  logic [FRAME_W-1:0] low_idx,
    input  logic               rd_used,
    input  logic [PID_W-1:0]   rd_pid,
    output logic               set_en,
    output logic [PID_W-1:0]   set_pid,
    output logic [FRAME_W-1:0] set_page,
    output logic               clr_en,
    output logic [FRAME_W-1:0] scan_idx,
    output logic               busy,
    output logic               alloc_fail,
    output logic               alloc_done,
    output logic               grant_valid,
    output logic [FRAME_W-1:0] grant_frame,
    output logic [FRAME_W-1:0] grant_page,
    output logic               rel_done,
    output logic [CNT_W-1:0]   free_count
);
    localparam logic [FRAME_W-1:0] LAST_IDX = FRAME_W'(NUM_FRAMES - 1);
    localparam logic [CNT_W-1:0]   FULL_CNT = CNT_W'(NUM_FRAMES);

    fat_state_e         state_q, state_d;
    logic [CNT_W-1:0]   remain_q;
    logic [FRAME_W-1:0] page_q;
    logic [PID_W-1:0]   pid_q;
    logic               take_rel, take_alloc, fits, zero_req, last_page, last_rec;

    assign take_rel   = (state_q == ST_IDLE) && rel_req;
    assign take_alloc = (state_q == ST_IDLE) && alloc_req && !rel_req;
    assign fits       = alloc_npages <= free_count;
    assign zero_req   = alloc_npages == '0;
    assign last_page  = remain_q == CNT_W'(1);
    assign last_rec   = scan_idx == LAST_IDX;

    assign set_en   = (state_q == ST_GRANT);
    assign set_pid  = pid_q;
    assign set_page = page_q;
    assign clr_en   = (state_q == ST_SCAN) && rd_used && (rd_pid == pid_q);
    assign busy     = (state_q != ST_IDLE);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (take_rel)
                    state_d = ST_SCAN;
                else if (take_alloc && fits && !zero_req)
                    state_d = ST_GRANT;
            end
            ST_GRANT: if (last_page) state_d = ST_IDLE;
            ST_SCAN:  if (last_rec)  state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            remain_q    <= '0;
            page_q      <= '0;
            pid_q       <= '0;
            scan_idx    <= '0;
            free_count  <= FULL_CNT;
            alloc_fail  <= 1'b0;
            alloc_done  <= 1'b0;
            grant_valid <= 1'b0;
            grant_frame <= '0;
            grant_page  <= '0;
            rel_done    <= 1'b0;
        end else begin
            alloc_fail  <= take_alloc && !fits;
            alloc_done  <= (set_en && last_page) || (take_alloc && fits && zero_req);
            grant_valid <= set_en;
            rel_done    <= (state_q == ST_SCAN) && last_rec;
            if (set_en) begin
                grant_frame <= low_idx;
                grant_page  <= page_q;
            end
            if (set_en)      free_count <= free_count - CNT_W'(1);
            else if (clr_en) free_count <= free_count + CNT_W'(1);
            unique case (state_q)
                ST_IDLE: begin
                    page_q   <= '0;
                    scan_idx <= '0;
                    if (take_rel)        pid_q <= rel_pid;
                    else if (take_alloc) pid_q <= alloc_pid;
                    remain_q <= alloc_npages;
                end
                ST_GRANT: begin
                    remain_q <= remain_q - CNT_W'(1);
                    page_q   <= page_q + FRAME_W'(1);
                end
                ST_SCAN: begin
                    scan_idx <= scan_idx + FRAME_W'(1);
                end
                default: ;
            endcase
        end
    end

    a_r5_count_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        free_count <= FULL_CNT);
    a_r5_grant_lowers_count: assert property (@(posedge clk) disable iff (!rst_n)
        grant_valid |-> free_count == $past(free_count) - CNT_W'(1));
    a_r4_grant_has_free: assert property (@(posedge clk) disable iff (!rst_n)
        set_en |-> any_free);
    a_r3_page_ascends: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_valid && $past(grant_valid)) |-> grant_page == $past(grant_page) + FRAME_W'(1));
    a_r2_fail_idle: assert property (@(posedge clk) disable iff (!rst_n)
        alloc_fail |-> (!busy && !grant_valid));
    a_r6_done_after_scan: assert property (@(posedge clk) disable iff (!rst_n)
        rel_done |-> $past(state_q) == ST_SCAN);
    a_r7_pid_held: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(pid_q));
endmodule

// File: rtl/frame_alloc_table.sv
module frame_alloc_table #(
    parameter int NUM_FRAMES = 16,
    parameter int PID_W      = 4,
    localparam int FRAME_W = (NUM_FRAMES > 1) ? $clog2(NUM_FRAMES) : 1,
    localparam int CNT_W   = $clog2(NUM_FRAMES + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               alloc_req,
    input  logic [PID_W-1:0]   alloc_pid,
    input  logic [CNT_W-1:0]   alloc_npages,
    input  logic               rel_req,
    input  logic [PID_W-1:0]   rel_pid,
    output logic               busy,
    output logic               alloc_fail,
    output logic               alloc_done,
    output logic               grant_valid,
    output logic [FRAME_W-1:0] grant_frame,
    output logic [FRAME_W-1:0] grant_page,
    output logic               rel_done,
    output logic [CNT_W-1:0]   free_count
);
    logic [NUM_FRAMES-1:0] free_vec;
    logic                  any_free;
    logic [FRAME_W-1:0]    low_idx;
    logic                  set_en, clr_en, rd_used;
    logic [PID_W-1:0]      set_pid, rd_pid;
    logic [FRAME_W-1:0]    set_page, scan_idx;

    fat_lowest_free #(.NUM_FRAMES(NUM_FRAMES)) u_pick (
        .free_vec (free_vec),
        .any_free (any_free),
        .low_idx  (low_idx)
    );

    fat_entry_store #(.NUM_FRAMES(NUM_FRAMES), .PID_W(PID_W)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_en   (set_en),
        .set_idx  (low_idx),
        .set_pid  (set_pid),
        .set_page (set_page),
        .clr_en   (clr_en),
        .clr_idx  (scan_idx),
        .rd_idx   (scan_idx),
        .rd_used  (rd_used),
        .rd_pid   (rd_pid),
        .free_vec (free_vec)
    );

    fat_ctrl #(.NUM_FRAMES(NUM_FRAMES), .PID_W(PID_W)) u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .alloc_req    (alloc_req),
        .alloc_pid    (alloc_pid),
        .alloc_npages (alloc_npages),
        .rel_req      (rel_req),
        .rel_pid      (rel_pid),
        .any_free     (any_free),
        .low_idx      (low_idx),
        .rd_used      (rd_used),
        .rd_pid       (rd_pid),
        .set_en       (set_en),
        .set_pid      (set_pid),
        .set_page     (set_page),
        .clr_en       (clr_en),
        .scan_idx     (scan_idx),
        .busy         (busy),
        .alloc_fail   (alloc_fail),
        .alloc_done   (alloc_done),
        .grant_valid  (grant_valid),
        .grant_frame  (grant_frame),
        .grant_page   (grant_page),
        .rel_done     (rel_done),
        .free_count   (free_count)
    );
endmodule

// File: tb/frame_alloc_table_bench.sv
module frame_alloc_table_bench;
    localparam int CLK_PERIOD = 10;
    localparam int NF = 8;
    localparam int PW = 3;
    localparam int FW = 3;
    localparam int CW = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          alloc_req = 1'b0;
    logic [PW-1:0] alloc_pid = '0;
    logic [CW-1:0] alloc_npages = '0;
    logic          rel_req = 1'b0;
    logic [PW-1:0] rel_pid = '0;
    logic          busy, alloc_fail, alloc_done, grant_valid, rel_done;
    logic [FW-1:0] grant_frame, grant_page;
    logic [CW-1:0] free_count;

    int checks = 0;
    int failures = 0;
    logic [2*FW-1:0] exp_q[$];
    logic            m_used[NF];
    logic [PW-1:0]   m_pid[NF];
    int              m_free;

    always #(CLK_PERIOD/2) clk = ~clk;

    frame_alloc_table #(.NUM_FRAMES(NF), .PID_W(PW)) u_frame_alloc_table (
        .clk(clk), .rst_n(rst_n),
        .alloc_req(alloc_req), .alloc_pid(alloc_pid), .alloc_npages(alloc_npages),
        .rel_req(rel_req), .rel_pid(rel_pid),
        .busy(busy), .alloc_fail(alloc_fail), .alloc_done(alloc_done),
        .grant_valid(grant_valid), .grant_frame(grant_frame), .grant_page(grant_page),
        .rel_done(rel_done), .free_count(free_count)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // monitor: pops expected grants as the design presents them
    always @(negedge clk) begin
        if (rst_n && grant_valid) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R7 unexpected grant", int'(grant_frame), -1);
            end else begin
                logic [2*FW-1:0] e;
                e = exp_q.pop_front();
                chk(grant_frame == e[2*FW-1:FW], "R4 grant frame", int'(grant_frame), int'(e[2*FW-1:FW]));
                chk(grant_page == e[FW-1:0], "R3 grant page", int'(grant_page), int'(e[FW-1:0]));
            end
        end
    end

    task automatic do_alloc(input int pid, input int n);
        int waited;
        bit ok;
        ok = (n <= m_free);
        if (ok) begin
            for (int p = 0; p < n; p++) begin
                for (int f = 0; f < NF; f++) begin
                    if (!m_used[f]) begin
                        m_used[f] = 1'b1;
                        m_pid[f] = PW'(pid);
                        exp_q.push_back({FW'(f), FW'(p)});
                        break;
                    end
                end
            end
            m_free -= n;
        end
        alloc_req = 1'b1; alloc_pid = PW'(pid); alloc_npages = CW'(n);
        @(negedge clk);
        alloc_req = 1'b0;
        if (!ok) begin
            chk(alloc_fail == 1'b1, "R2 fail pulse", int'(alloc_fail), 1);
            chk(busy == 1'b0, "R2 busy stays low", int'(busy), 0);
        end else if (n == 0) begin
            chk(alloc_done == 1'b1, "R9 zero request done", int'(alloc_done), 1);
            chk(busy == 1'b0, "R9 no busy", int'(busy), 0);
        end else begin
            chk(busy == 1'b1 && grant_valid == 1'b0, "R3 first grant delay", int'(grant_valid), 0);
            waited = 0;
            while (!alloc_done && waited < 50) begin
                @(negedge clk);
                waited++;
            end
            chk(waited == n, "R3 grant cycles", waited, n);
        end
        @(negedge clk);
        chk(exp_q.size() == 0, "R3 all grants seen", exp_q.size(), 0);
        chk(int'(free_count) == m_free, "R5 free count", int'(free_count), m_free);
    endtask

    task automatic do_release(input int pid, input bit poke_alloc);
        int cyc;
        for (int f = 0; f < NF; f++) begin
            if (m_used[f] && m_pid[f] == PW'(pid)) begin
                m_used[f] = 1'b0;
                m_free++;
            end
        end
        rel_req = 1'b1; rel_pid = PW'(pid);
        @(negedge clk);
        rel_req = 1'b0;
        cyc = 0;
        while (!rel_done && cyc < 50) begin
            if (busy) cyc++;
            if (poke_alloc && cyc == 2) begin
                alloc_req = 1'b1; alloc_npages = CW'(1); rel_req = 1'b1; rel_pid = PW'(pid ^ 1);
            end else begin
                alloc_req = 1'b0; rel_req = 1'b0;
            end
            @(negedge clk);
        end
        alloc_req = 1'b0; rel_req = 1'b0;
        chk(cyc == NF, "R6 walk length", cyc, NF);
        chk(busy == 1'b0, "R6 idle after walk", int'(busy), 0);
        chk(int'(free_count) == m_free, "R6 frames freed", int'(free_count), m_free);
        @(negedge clk);
        chk(busy == 1'b0 && !grant_valid, "R7 ignored during busy", int'(busy), 0);
    endtask

    initial begin
        for (int f = 0; f < NF; f++) begin m_used[f] = 1'b0; m_pid[f] = '0; end
        m_free = NF;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(int'(free_count) == NF, "R1 reset free count", int'(free_count), NF);
        chk(!busy && !grant_valid && !alloc_fail && !alloc_done && !rel_done,
            "R1 reset outputs", int'(busy), 0);

        do_alloc(1, 3);
        do_alloc(2, 2);
        do_release(1, 1'b0);
        do_alloc(3, 4);          // R4 picks 0,1,2,5
        do_alloc(4, 3);          // R2 only 2 free
        do_alloc(4, 2);
        do_alloc(5, 1);          // R2 table full
        do_alloc(5, 0);          // R9
        do_release(6, 1'b0);     // owns nothing
        do_release(2, 1'b1);     // R7 requests poked during walk

        // R8: simultaneous requests, release wins
        for (int f = 0; f < NF; f++)
            if (m_used[f] && m_pid[f] == 3'd3) begin m_used[f] = 1'b0; m_free++; end
        alloc_req = 1'b1; alloc_npages = CW'(1); alloc_pid = 3'd6;
        rel_req = 1'b1; rel_pid = 3'd3;
        @(negedge clk);
        alloc_req = 1'b0; rel_req = 1'b0;
        chk(busy == 1'b1 && !alloc_fail, "R8 release taken", int'(busy), 1);
        while (!rel_done) @(negedge clk);
        @(negedge clk);
        chk(int'(free_count) == m_free, "R8 alloc dropped", int'(free_count), m_free);
        chk(exp_q.size() == 0, "R8 no grant", exp_q.size(), 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        chk(1'b0, "watchdog", 0, 1);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule